// File: doc/BRIEF.md
# Firmware glue register controller

This block gives boot firmware a handful of system services behind one small memory-mapped window. A single-cycle bus request is decoded on the low six bits of its address. From there firmware can stop the run with an exit code, learn which processor is asking and how many processors are present, and drive the level of one interrupt line per processor. A one-character console is also reachable through this window.

Interrupt control uses one two-byte store. The low byte lane names the target line and the high byte lane carries the level. The console has no host terminal behind it. On the input side, a character-valid signal and a ready pulse let an outside source offer characters, and a read of the input status register is what takes one. On the output side, a one-cycle valid strobe carries each emitted character. Read data comes back one clock after the request.

Top module: `fwglue_ctrl`

## Requirements
- R1: Decode uses only bus_addr[5:0]. Register offsets: 0 halt, 4 processor index, 8 interrupt, 12 processor count, 16 input character, 20 input status, 24 output character, 28 output status. A read of any other offset returns zero, and a write to any other offset changes nothing.
- R2: A write to offset 0 with bus_be[0] set raises halt and presents bus_wdata[7:0] on exit_code. Halt stays high until reset, and later writes to offset 0 leave exit_code unchanged.
- R3: A read of offset 4 returns bus_cpu_id. A read of offset 12 returns the CPU_COUNT parameter, or 1 when CPU_COUNT is 0.
- R4: A write to offset 8 with both byte enables set selects line bus_wdata[7:0] and drives it to 1 if bus_wdata[15:8] is nonzero, otherwise to 0. Each line holds its level until that same line is written again.
- R5: A write to offset 8 with bus_be equal to 2'b01 drives the selected line to 0. The write is ignored in two cases: bus_be[0] is clear, or the line index is at or above the processor count.
- R6: A read of offset 20 samples the console. If con_in_valid is high, con_in_ready pulses in that cycle, the character is latched and the status becomes 1. Otherwise the latched character and the status are both cleared to 0.
- R7: A read of offset 16 returns the latched character and does not sample the console (con_in_ready stays low).
- R8: A write to offset 24 emits the character on con_out_char with con_out_valid high for exactly the following cycle. The write also keeps the character for readback at offset 24 and sets the output status to 1.
- R9: Writes to offsets 16, 20 and 28 with bus_be[0] set load bus_wdata[7:0] into the input character, the input status and the output status.
- R10: After reset, the output status is 1 and the output character is 0. The input status and input character are 0, all interrupt lines are 0, halt is 0 and exit_code is 0.
- R11: Read data is returned on bus_rdata the cycle after the request, with byte registers zero-extended. In cycles that follow no read, bus_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address; only the low 6 bits decode |
| bus_be | input | 2 | Byte enables, [1] high lane, [0] low lane |
| bus_wdata | input | 16 | Write data |
| bus_cpu_id | input | CPU_IDX_W | Index of the requesting processor |
| bus_rdata | output | 16 | Read data, one cycle after the request |
| halt | output | 1 | Run stop request |
| exit_code | output | 8 | Exit status written with the halt |
| irq | output | NUM_CPU | Per-processor interrupt levels |
| con_in_valid | input | 1 | Console character waiting |
| con_in_char | input | 8 | Waiting console character |
| con_in_ready | output | 1 | Character taken this cycle |
| con_out_valid | output | 1 | Character emitted |
| con_out_char | output | 8 | Emitted character |

## Verification
The hardest state to reach is a console sample whose outcome depends on timing. The bench must offer a character exactly in the cycle of an input status read and watch the ready pulse before the clock edge. It must then read the input character register while a different character is waiting, to prove that no second sample happens. The stimulus therefore drives con_in_valid together with the request and checks con_in_ready mid-cycle. Interrupt coverage walks several lines through the same register with full and partial byte enables, and with an index past the processor count.

// File: rtl/fwglue_pkg.sv
package fwglue_pkg;
  localparam int OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_HALT   = 6'd0;
  localparam logic [OFF_W-1:0] OFF_CPUID  = 6'd4;
  localparam logic [OFF_W-1:0] OFF_IRQ    = 6'd8;
  localparam logic [OFF_W-1:0] OFF_NCPU   = 6'd12;
  localparam logic [OFF_W-1:0] OFF_INCHR  = 6'd16;
  localparam logic [OFF_W-1:0] OFF_INSTS  = 6'd20;
  localparam logic [OFF_W-1:0] OFF_OUTCHR = 6'd24;
  localparam logic [OFF_W-1:0] OFF_OUTSTS = 6'd28;

  typedef struct packed {
    logic halt;
    logic cpuid;
    logic irq;
    logic ncpu;
    logic inchr;
    logic insts;
    logic outchr;
    logic outsts;
  } reg_hit_t;
endpackage

// File: rtl/fwglue_decode.sv
module fwglue_decode
  import fwglue_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_hit_t          hit
);
  logic [OFF_W-1:0] off;

  always_comb begin
    off        = addr[OFF_W-1:0];
    hit        = '0;
    hit.halt   = (off == OFF_HALT);
    hit.cpuid  = (off == OFF_CPUID);
    hit.irq    = (off == OFF_IRQ);
    hit.ncpu   = (off == OFF_NCPU);
    hit.inchr  = (off == OFF_INCHR);
    hit.insts  = (off == OFF_INSTS);
    hit.outchr = (off == OFF_OUTCHR);
    hit.outsts = (off == OFF_OUTSTS);
  end
endmodule

// File: rtl/fwglue_console.sv
module fwglue_console #(
  parameter int CHR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_insts,
  input  logic             wr_inchr,
  input  logic             wr_insts,
  input  logic             wr_outchr,
  input  logic             wr_outsts,
  input  logic [CHR_W-1:0] wbyte,
  input  logic             con_in_valid,
  input  logic [CHR_W-1:0] con_in_char,
  output logic             con_in_ready,
  output logic             con_out_valid,
  output logic [CHR_W-1:0] con_out_char,
  output logic [CHR_W-1:0] in_chr,
  output logic [CHR_W-1:0] in_sts,
  output logic [CHR_W-1:0] out_chr,
  output logic [CHR_W-1:0] out_sts
);
  logic [CHR_W-1:0] in_chr_nx, in_sts_nx, out_chr_nx, out_sts_nx;
  logic             in_en, out_chr_en, out_sts_en;

  assign con_in_ready  = rd_insts & con_in_valid;
  assign con_out_char  = out_chr;

  always_comb begin
    in_en      = rd_insts | wr_inchr | wr_insts;
    in_chr_nx  = in_chr;
    in_sts_nx  = in_sts;
    if (rd_insts) begin
      in_chr_nx = con_in_valid ? con_in_char : '0;
      in_sts_nx = con_in_valid ? CHR_W'(1) : '0;
    end else begin
      if (wr_inchr) in_chr_nx = wbyte;
      if (wr_insts) in_sts_nx = wbyte;
    end
    out_chr_en = wr_outchr;
    out_chr_nx = wbyte;
    out_sts_en = wr_outchr | wr_outsts;
    out_sts_nx = wr_outchr ? CHR_W'(1) : wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_chr        <= '0;
      in_sts        <= '0;
      out_chr       <= '0;
      out_sts       <= CHR_W'(1);
      con_out_valid <= 1'b0;
    end else begin
      if (in_en) begin
        in_chr <= in_chr_nx;
        in_sts <= in_sts_nx;
      end
      if (out_chr_en) out_chr <= out_chr_nx;
      if (out_sts_en) out_sts <= out_sts_nx;
      con_out_valid <= wr_outchr;
    end
  end
endmodule

// File: rtl/fwglue_irq.sv
module fwglue_irq #(
  parameter int NUM_CPU   = 4,
  parameter int EFF_COUNT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_irq,
  input  logic [1:0]         be,
  input  logic [15:0]        wdata,
  output logic [NUM_CPU-1:0] irq
);
  logic       lvl;
  logic [7:0] port;

  always_comb begin
    port = wdata[7:0];
    lvl  = be[1] ? (|wdata[15:8]) : 1'b0;
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_line
    if (i < EFF_COUNT) begin : g_live
      logic en;
      always_comb en = wr_irq & be[0] & (port == 8'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  irq[i] <= 1'b0;
        else if (en) irq[i] <= lvl;
      end
    end else begin : g_dead
      assign irq[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fwglue_ctrl.sv
module fwglue_ctrl
  import fwglue_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CPU   = 4,
  parameter int CPU_COUNT = 3,
  parameter int CPU_IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [1:0]           bus_be,
  input  logic [15:0]          bus_wdata,
  input  logic [CPU_IDX_W-1:0] bus_cpu_id,
  output logic [15:0]          bus_rdata,
  output logic                 halt,
  output logic [7:0]           exit_code,
  output logic [NUM_CPU-1:0]   irq,
  input  logic                 con_in_valid,
  input  logic [7:0]           con_in_char,
  output logic                 con_in_ready,
  output logic                 con_out_valid,
  output logic [7:0]           con_out_char
);
  localparam int EFF_COUNT = (CPU_COUNT == 0) ? 1 : CPU_COUNT;

  reg_hit_t   hit;
  logic       rd, wr, wr_b0;
  logic [7:0] in_chr, in_sts, out_chr, out_sts;
  logic [15:0] rdata_nx;
  logic       halt_nx, halt_en;
  logic [7:0] exit_nx;

  fwglue_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .hit(hit));

  assign rd    = bus_sel & ~bus_we;
  assign wr    = bus_sel & bus_we;
  assign wr_b0 = wr & bus_be[0];

  fwglue_console #(.CHR_W(8)) u_con (
    .clk(clk), .rst_n(rst_n),
    .rd_insts(rd & hit.insts),
    .wr_inchr(wr_b0 & hit.inchr),
    .wr_insts(wr_b0 & hit.insts),
    .wr_outchr(wr_b0 & hit.outchr),
    .wr_outsts(wr_b0 & hit.outsts),
    .wbyte(bus_wdata[7:0]),
    .con_in_valid(con_in_valid), .con_in_char(con_in_char),
    .con_in_ready(con_in_ready),
    .con_out_valid(con_out_valid), .con_out_char(con_out_char),
    .in_chr(in_chr), .in_sts(in_sts), .out_chr(out_chr), .out_sts(out_sts)
  );

  fwglue_irq #(.NUM_CPU(NUM_CPU), .EFF_COUNT(EFF_COUNT)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .wr_irq(wr & hit.irq), .be(bus_be), .wdata(bus_wdata), .irq(irq)
  );

  always_comb begin
    halt_en = wr_b0 & hit.halt & ~halt;
    halt_nx = 1'b1;
    exit_nx = bus_wdata[7:0];
  end

  always_comb begin
    rdata_nx = '0;
    if (rd) begin
      unique case (1'b1)
        hit.cpuid:  rdata_nx = 16'(bus_cpu_id);
        hit.ncpu:   rdata_nx = 16'(EFF_COUNT);
        hit.inchr:  rdata_nx = {8'h00, in_chr};
        hit.insts:  rdata_nx = con_in_valid ? 16'd1 : 16'd0;
        hit.outchr: rdata_nx = {8'h00, out_chr};
        hit.outsts: rdata_nx = {8'h00, out_sts};
        default:    rdata_nx = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt      <= 1'b0;
      exit_code <= '0;
      bus_rdata <= '0;
    end else begin
      if (halt_en) begin
        halt      <= halt_nx;
        exit_code <= exit_nx;
      end
      bus_rdata <= rdata_nx;
    end
  end
endmodule

// File: rtl/fwglue_ctrl_chk.sv
module fwglue_ctrl_chk #(
  parameter int ADDR_W    = 8,
  parameter int NUM_CPU   = 4,
  parameter int CPU_COUNT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [1:0]         bus_be,
  input logic [15:0]        bus_wdata,
  input logic               halt,
  input logic [7:0]         exit_code,
  input logic [NUM_CPU-1:0] irq,
  input logic               con_in_valid,
  input logic               con_in_ready,
  input logic               con_out_valid
);
  localparam int EFF = (CPU_COUNT == 0) ? 1 : CPU_COUNT;
  logic [5:0] off;
  logic       irq_wr;
  assign off    = bus_addr[5:0];
  assign irq_wr = bus_sel & bus_we & (off == 6'd8);

  p_halt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt && $stable(exit_code));

  p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_wr |=> $stable(irq));

  p_irq_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_wr && (32'(bus_wdata[7:0]) >= EFF)) |=> $stable(irq));

  p_irq_nolane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_wr && !bus_be[0]) |=> $stable(irq));

  p_ready_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    con_in_ready |-> con_in_valid && bus_sel && !bus_we);

  p_out_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    con_out_valid |-> $past(bus_sel && bus_we && off == 6'd24));
endmodule

bind fwglue_ctrl fwglue_ctrl_chk #(
  .ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .CPU_COUNT(CPU_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
  .halt(halt), .exit_code(exit_code), .irq(irq),
  .con_in_valid(con_in_valid), .con_in_ready(con_in_ready),
  .con_out_valid(con_out_valid)
);

// File: tb/fwglue_ctrl_bench.sv
module fwglue_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_cpu_id = '0;
  logic        con_in_valid = 1'b0;
  logic [7:0]  con_in_char = '0;

  logic [15:0] rdata, rdata_u;
  logic        halt, halt_u, ready, ready_u, ovld, ovld_u;
  logic [7:0]  code, code_u, ochr, ochr_u;
  logic [3:0]  irq, irq_u;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  fwglue_ctrl u_fwglue_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_cpu_id(bus_cpu_id), .bus_rdata(rdata), .halt(halt),
    .exit_code(code), .irq(irq), .con_in_valid(con_in_valid),
    .con_in_char(con_in_char), .con_in_ready(ready),
    .con_out_valid(ovld), .con_out_char(ochr));

  fwglue_ctrl #(.CPU_COUNT(0)) u_unset (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_cpu_id(bus_cpu_id), .bus_rdata(rdata_u), .halt(halt_u),
    .exit_code(code_u), .irq(irq_u), .con_in_valid(con_in_valid),
    .con_in_char(con_in_char), .con_in_ready(ready_u),
    .con_out_valid(ovld_u), .con_out_char(ochr_u));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge; returns at the next falling edge,
  // when the registered response of that request is visible.
  task automatic op(input logic we, input logic [1:0] be, input logic [7:0] a,
                    input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_be = be; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  // {we, be, addr, wdata, do_check, expected, requirement}
  localparam int NV = 14;
  localparam logic [47:0] VEC [NV] = '{
    {1'b1, 2'b01, 8'd24, 16'h0041, 1'b0, 16'h0000, 4'd8},  // R8 emit 'A'
    {1'b0, 2'b01, 8'd24, 16'h0000, 1'b1, 16'h0041, 4'd8},  // R8 readback
    {1'b0, 2'b01, 8'd28, 16'h0000, 1'b1, 16'h0001, 4'd8},  // R8 status set
    {1'b1, 2'b01, 8'd28, 16'h0000, 1'b0, 16'h0000, 4'd9},  // R9 clear out status
    {1'b0, 2'b01, 8'd28, 16'h0000, 1'b1, 16'h0000, 4'd9},  // R9
    {1'b1, 2'b01, 8'd16, 16'h005A, 1'b0, 16'h0000, 4'd9},  // R9 load in char
    {1'b0, 2'b01, 8'd16, 16'h0000, 1'b1, 16'h005A, 4'd9},  // R9
    {1'b0, 2'b01, 8'd20, 16'h0000, 1'b1, 16'h0000, 4'd6},  // R6 empty sample
    {1'b0, 2'b01, 8'd16, 16'h0000, 1'b1, 16'h0000, 4'd6},  // R6 char cleared
    {1'b0, 2'b01, 8'd12, 16'h0000, 1'b1, 16'h0003, 4'd3},  // R3 count
    {1'b0, 2'b01, 8'd76, 16'h0000, 1'b1, 16'h0003, 4'd1},  // R1 alias 64+12
    {1'b0, 2'b01, 8'd36, 16'h0000, 1'b1, 16'h0000, 4'd1},  // R1 unmapped read
    {1'b1, 2'b11, 8'd40, 16'h0000, 1'b0, 16'h0000, 4'd1},  // R1 unmapped write
    {1'b0, 2'b01, 8'd24, 16'h0000, 1'b1, 16'h0041, 4'd1}   // R1 nothing changed
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check("R10 halt", 16'(halt), 16'd0);
    check("R10 exit", 16'(code), 16'd0);
    check("R10 irq", 16'(irq), 16'd0);
    op(1'b0, 2'b01, 8'd28, 16'h0); check("R10 out status", rdata, 16'd1);
    op(1'b0, 2'b01, 8'd24, 16'h0); check("R10 out char", rdata, 16'd0);
    op(1'b0, 2'b01, 8'd16, 16'h0); check("R10 in char", rdata, 16'd0);
    @(negedge clk); check("R11 idle rdata", rdata, 16'd0);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][47], VEC[i][46:45], VEC[i][44:37], VEC[i][36:21]);
      if (VEC[i][20]) check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rdata, VEC[i][19:4]);
    end

    // R4 two-byte stores
    op(1'b1, 2'b11, 8'd8, 16'h0102); check("R4 line2", 16'(irq), 16'h4);
    op(1'b1, 2'b11, 8'd8, 16'h0501); check("R4 line1", 16'(irq), 16'h6);
    op(1'b1, 2'b11, 8'd8, 16'h0001); check("R4 line1 low", 16'(irq), 16'h4);
    // R5 partial lanes and out-of-range line
    op(1'b1, 2'b01, 8'd8, 16'hFF02); check("R5 one byte", 16'(irq), 16'h0);
    op(1'b1, 2'b11, 8'd8, 16'h0100); check("R4 line0", 16'(irq), 16'h1);
    op(1'b1, 2'b11, 8'd8, 16'h0103); check("R5 range", 16'(irq), 16'h1);
    op(1'b1, 2'b10, 8'd8, 16'h0101); check("R5 no low lane", 16'(irq), 16'h1);

    // R6 sample with a character waiting
    @(negedge clk);
    con_in_valid = 1'b1; con_in_char = 8'h33;
    bus_sel = 1'b1; bus_we = 1'b0; bus_be = 2'b01; bus_addr = 8'd20;
    #2 check("R6 ready pulse", 16'(ready), 16'd1);
    @(negedge clk);
    bus_sel = 1'b0;
    check("R6 status one", rdata, 16'd1);
    // R7 char read does not sample again
    con_in_char = 8'h44;
    @(negedge clk);
    bus_sel = 1'b1; bus_addr = 8'd16;
    #2 check("R7 no ready", 16'(ready), 16'd0);
    @(negedge clk);
    bus_sel = 1'b0; con_in_valid = 1'b0;
    check("R7 latched char", rdata, 16'h33);

    // R8 output strobe
    op(1'b1, 2'b01, 8'd24, 16'h007E);
    check("R8 valid", 16'(ovld), 16'd1);
    check("R8 char", 16'(ochr), 16'h7E);
    @(negedge clk); check("R8 one cycle", 16'(ovld), 16'd0);

    // R3 id and unset count
    bus_cpu_id = 2'd2;
    op(1'b0, 2'b01, 8'd4, 16'h0); check("R3 id", rdata, 16'd2);
    op(1'b0, 2'b01, 8'd12, 16'h0); check("R3 unset count", rdata_u, 16'd1);

    // R2 halt
    op(1'b1, 2'b01, 8'd0, 16'h002A);
    check("R2 halt", 16'(halt), 16'd1);
    check("R2 code", 16'(code), 16'h2A);
    op(1'b1, 2'b01, 8'd0, 16'h0011);
    check("R2 code kept", 16'(code), 16'h2A);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule